// File: doc/BRIEF.md
# Segment Base Register Unit

This unit keeps the hidden 64-bit base addresses of the FS and GS data segments and an alternate GS base reserved for kernel code. Three update paths reach these registers. A model-specific-register (MSR) write selects its target by a 32-bit index and replaces all 64 bits at once from two 32-bit halves. A segment-selector load brings in a descriptor that has already been fetched, extracts the 32-bit base scattered across it, and rewrites only the low half of FS or GS. A privileged swap exchanges GS with the alternate base in one cycle. MSR reads return the addressed register in the same cycle.

The unit also forms effective addresses. It adds the base of the chosen segment to an incoming offset. In 64-bit mode the sum is the full 64 bits. In compatibility mode only the low 32 bits of the base take part, and the result is cut to 32 bits. The result comes out registered, one cycle after the request.

Top module: `seg_base_unit`

## Requirements
- R1: MSR index 0xC0000100 addresses the FS base, 0xC0000101 the GS base and 0xC0000102 the alternate GS base. A read (msr_rd_i) returns the addressed 64-bit value on msr_rdata_o in the same cycle.
- R2: An MSR write to a recognised index replaces all 64 bits of the target at the next clock edge: bits 63..32 from msr_wdata_hi_i and bits 31..0 from msr_wdata_lo_i.
- R3: A selector load (sel_ld_i, with sel_seg_i 0 = FS and 1 = GS) writes a 32-bit base into bits 31..0 of the target and keeps bits 63..32. Base bits 31..24 come from desc_i[63:56], bits 23..16 from desc_i[39:32] and bits 15..0 from desc_i[31:16]. All other descriptor bits are ignored.
- R4: In compatibility mode (mode64_i = 0) ea_o is (base[31:0] + offset[31:0]) mod 2^32, and bits 63..32 of ea_o are zero. This holds whatever the upper half of the base holds.
- R5: In 64-bit mode (mode64_i = 1) ea_o is (base + offset) mod 2^64.
- R6: ea_valid_o and ea_o appear one cycle after ea_valid_i, and ea_valid_o drops one cycle after ea_valid_i drops. ea_seg_i selects the base: 0 = FS, 1 = GS. The base used is the register value from before any update at that same edge.
- R7: A swap (swap_i) in 64-bit mode with cpl_i = 0 exchanges the GS base and the alternate base at one clock edge.
- R8: A swap with cpl_i other than 0, or with mode64_i = 0, leaves both registers unchanged. swap_fault_o is then high for exactly the one cycle after the request.
- R9: A read or write to any other index raises msr_err_o in the same cycle. A read then returns zero, and a write changes no register.
- R10: After reset all three bases read zero, and ea_valid_o and swap_fault_o are low.
- R11: When an MSR write and a selector load hit the same register in one cycle, the MSR write wins. A permitted swap in a cycle that also writes GS or the alternate base (by MSR or by selector load) is dropped without a fault, and the write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode64_i | input | 1 | 1 = 64-bit mode, 0 = compatibility mode |
| cpl_i | input | 2 | Current privilege level |
| msr_wr_i | input | 1 | MSR write request |
| msr_rd_i | input | 1 | MSR read request |
| msr_idx_i | input | 32 | MSR index |
| msr_wdata_lo_i | input | 32 | Write data, bits 31..0 |
| msr_wdata_hi_i | input | 32 | Write data, bits 63..32 |
| msr_rdata_o | output | 64 | Read data |
| msr_err_o | output | 1 | Unknown MSR index on read or write |
| sel_ld_i | input | 1 | Selector load request |
| sel_seg_i | input | 1 | Selector load target, 0 = FS, 1 = GS |
| desc_i | input | 64 | Descriptor, already fetched |
| swap_i | input | 1 | Swap request for GS and the alternate base |
| swap_fault_o | output | 1 | Refused swap, one-cycle pulse |
| ea_valid_i | input | 1 | Address request valid |
| ea_seg_i | input | 1 | Address segment, 0 = FS, 1 = GS |
| ea_off_i | input | 64 | Offset |
| ea_valid_o | output | 1 | Effective address valid |
| ea_o | output | 64 | Effective address |

## Verification
Some behaviours are checked by the assertions on every cycle: a permitted swap really exchanges the two registers, a refused swap leaves them unchanged and raises the fault, a selector load keeps the upper half of its target, an unknown-index write leaves all bases unchanged, and compatibility results carry a zero upper half. The bench sweeps MSR values, descriptor patterns with noise in the unused fields, every privilege level in both modes, and offsets that carry across bit 31 and bit 63. It checks values that only a full scenario can show: the field assembly, the modular sums, the one-cycle latency and the results of colliding updates.

// File: rtl/seg_base_pkg.sv
package seg_base_pkg;
  typedef enum logic [1:0] {
    SEG_FS   = 2'd0,
    SEG_GS   = 2'd1,
    SEG_ALT  = 2'd2,
    SEG_NONE = 2'd3
  } seg_reg_e;
endpackage

// File: rtl/seg_msr_decode.sv
module seg_msr_decode
  import seg_base_pkg::*;
#(
  parameter int unsigned IDX_W = 32,
  parameter logic [IDX_W-1:0] IDX_FS  = 32'hC000_0100,
  parameter logic [IDX_W-1:0] IDX_GS  = 32'hC000_0101,
  parameter logic [IDX_W-1:0] IDX_ALT = 32'hC000_0102
) (
  input  logic [IDX_W-1:0] idx_i,
  output seg_reg_e         tgt_o,
  output logic             hit_o
);
  always_comb begin
    unique case (idx_i)
      IDX_FS:  tgt_o = SEG_FS;
      IDX_GS:  tgt_o = SEG_GS;
      IDX_ALT: tgt_o = SEG_ALT;
      default: tgt_o = SEG_NONE;
    endcase
  end
  assign hit_o = (tgt_o != SEG_NONE);
endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack #(
  parameter int unsigned DESC_W = 64,
  parameter int unsigned BASE_W = 32
) (
  input  logic [DESC_W-1:0] desc_i,
  output logic [BASE_W-1:0] base_o
);
  // base[31:24] <- d[63:56], base[23:16] <- d[39:32], base[15:0] <- d[31:16]
  localparam int unsigned TOP_LSB = DESC_W - 8;
  assign base_o = {desc_i[DESC_W-1:TOP_LSB], desc_i[39:32], desc_i[31:16]};

  logic unused_desc;
  assign unused_desc = ^{desc_i[TOP_LSB-1:40], desc_i[15:0]};
endmodule

// File: rtl/seg_base_regs.sv
module seg_base_regs
  import seg_base_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LO_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msr_wr_i,
  input  seg_reg_e          msr_tgt_i,
  input  logic [ADDR_W-1:0] msr_wdata_i,
  input  logic              sel_ld_i,
  input  logic              sel_seg_i,
  input  logic [LO_W-1:0]   sel_base_i,
  input  logic              swap_i,
  input  logic              swap_ok_i,
  output logic [ADDR_W-1:0] fs_o,
  output logic [ADDR_W-1:0] gs_o,
  output logic [ADDR_W-1:0] alt_o,
  output logic              fault_o
);
  localparam int unsigned HI_W = ADDR_W - LO_W;

  logic wr_fs, wr_gs, wr_alt, ld_fs, ld_gs, gs_busy, do_swap;

  assign wr_fs   = msr_wr_i && (msr_tgt_i == SEG_FS);
  assign wr_gs   = msr_wr_i && (msr_tgt_i == SEG_GS);
  assign wr_alt  = msr_wr_i && (msr_tgt_i == SEG_ALT);
  assign ld_fs   = sel_ld_i && !sel_seg_i && !wr_fs;
  assign ld_gs   = sel_ld_i &&  sel_seg_i && !wr_gs;
  assign gs_busy = wr_gs || wr_alt || (sel_ld_i && sel_seg_i);
  assign do_swap = swap_i && swap_ok_i && !gs_busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_o <= '0;
    end else if (wr_fs) begin
      fs_o <= msr_wdata_i;
    end else if (ld_fs) begin
      fs_o[LO_W-1:0] <= sel_base_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gs_o  <= '0;
      alt_o <= '0;
    end else if (do_swap) begin
      gs_o  <= alt_o;
      alt_o <= gs_o;
    end else begin
      if (wr_gs)      gs_o <= msr_wdata_i;
      else if (ld_gs) gs_o[LO_W-1:0] <= sel_base_i;
      if (wr_alt)     alt_o <= msr_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fault_o <= 1'b0;
    else         fault_o <= swap_i && !swap_ok_i;
  end

  a_r7_swap_exchange: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && swap_ok_i && !msr_wr_i && !sel_ld_i)
      |=> (gs_o == $past(alt_o)) && (alt_o == $past(gs_o)));

  a_r8_refused_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (swap_i && !swap_ok_i && !msr_wr_i && !sel_ld_i)
      |=> fault_o && $stable(gs_o) && $stable(alt_o));

  a_r3_keep_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ld_i && !sel_seg_i && !msr_wr_i)
      |=> (fs_o[ADDR_W-1:LO_W] == $past(fs_o[ADDR_W-1:LO_W]))
          && (fs_o[LO_W-1:0] == $past(sel_base_i)));

  a_r11_msr_beats_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_gs && sel_ld_i && sel_seg_i) |=> (gs_o == $past(msr_wdata_i)));

  logic unused_hi;
  assign unused_hi = (HI_W == 0);
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LO_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              seg_i,
  input  logic              mode64_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic [ADDR_W-1:0] fs_i,
  input  logic [ADDR_W-1:0] gs_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] ea_o
);
  localparam int unsigned HI_W = ADDR_W - LO_W;

  logic [ADDR_W-1:0] base, sum_full, ea_d;
  logic [LO_W-1:0]   sum_lo;
  logic              mode_q;

  assign base     = seg_i ? gs_i : fs_i;
  assign sum_full = base + off_i;
  assign sum_lo   = base[LO_W-1:0] + off_i[LO_W-1:0];
  assign ea_d     = mode64_i ? sum_full : {{HI_W{1'b0}}, sum_lo};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mode_q  <= 1'b0;
      ea_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        mode_q <= mode64_i;
        ea_o   <= ea_d;
      end
    end
  end

  a_r4_compat_high_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !mode_q) |-> (ea_o[ADDR_W-1:LO_W] == '0));

  a_r6_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
endmodule

// File: rtl/seg_base_unit.sv
module seg_base_unit
  import seg_base_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LO_W   = 32,
  parameter int unsigned IDX_W  = 32,
  parameter int unsigned DESC_W = 64,
  parameter int unsigned CPL_W  = 2,
  parameter logic [IDX_W-1:0] IDX_FS  = 32'hC000_0100,
  parameter logic [IDX_W-1:0] IDX_GS  = 32'hC000_0101,
  parameter logic [IDX_W-1:0] IDX_ALT = 32'hC000_0102
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode64_i,
  input  logic [CPL_W-1:0]  cpl_i,
  input  logic              msr_wr_i,
  input  logic              msr_rd_i,
  input  logic [IDX_W-1:0]  msr_idx_i,
  input  logic [LO_W-1:0]   msr_wdata_lo_i,
  input  logic [ADDR_W-LO_W-1:0] msr_wdata_hi_i,
  output logic [ADDR_W-1:0] msr_rdata_o,
  output logic              msr_err_o,
  input  logic              sel_ld_i,
  input  logic              sel_seg_i,
  input  logic [DESC_W-1:0] desc_i,
  input  logic              swap_i,
  output logic              swap_fault_o,
  input  logic              ea_valid_i,
  input  logic              ea_seg_i,
  input  logic [ADDR_W-1:0] ea_off_i,
  output logic              ea_valid_o,
  output logic [ADDR_W-1:0] ea_o
);
  seg_reg_e          tgt;
  logic              hit, swap_ok;
  logic [LO_W-1:0]   sel_base;
  logic [ADDR_W-1:0] fs_q, gs_q, alt_q;

  seg_msr_decode #(.IDX_W(IDX_W), .IDX_FS(IDX_FS), .IDX_GS(IDX_GS), .IDX_ALT(IDX_ALT))
    u_dec (.idx_i(msr_idx_i), .tgt_o(tgt), .hit_o(hit));

  seg_desc_unpack #(.DESC_W(DESC_W), .BASE_W(LO_W))
    u_unpack (.desc_i(desc_i), .base_o(sel_base));

  assign swap_ok = mode64_i && (cpl_i == '0);

  seg_base_regs #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .msr_wr_i   (msr_wr_i && hit),
    .msr_tgt_i  (tgt),
    .msr_wdata_i({msr_wdata_hi_i, msr_wdata_lo_i}),
    .sel_ld_i   (sel_ld_i),
    .sel_seg_i  (sel_seg_i),
    .sel_base_i (sel_base),
    .swap_i     (swap_i),
    .swap_ok_i  (swap_ok),
    .fs_o       (fs_q),
    .gs_o       (gs_q),
    .alt_o      (alt_q),
    .fault_o    (swap_fault_o)
  );

  always_comb begin
    unique case (tgt)
      SEG_FS:  msr_rdata_o = fs_q;
      SEG_GS:  msr_rdata_o = gs_q;
      SEG_ALT: msr_rdata_o = alt_q;
      default: msr_rdata_o = '0;
    endcase
  end
  assign msr_err_o = (msr_wr_i || msr_rd_i) && !hit;

  seg_ea_gen #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_ea (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (ea_valid_i),
    .seg_i   (ea_seg_i),
    .mode64_i(mode64_i),
    .off_i   (ea_off_i),
    .fs_i    (fs_q),
    .gs_i    (gs_q),
    .valid_o (ea_valid_o),
    .ea_o    (ea_o)
  );

  a_r9_bad_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_wr_i && msr_err_o && !sel_ld_i && !swap_i)
      |=> $stable(fs_q) && $stable(gs_q) && $stable(alt_q));

  a_r9_bad_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msr_rd_i && msr_err_o) |-> (msr_rdata_o == '0));
endmodule

// File: tb/tb_seg_base_unit.sv
module tb_seg_base_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode64, msr_wr, msr_rd, sel_ld, sel_seg, swap, ea_valid, ea_seg;
  logic [1:0]  cpl;
  logic [31:0] idx, wlo, whi;
  logic [63:0] rdata, desc, ea_off, ea;
  logic        err, fault, ea_vo;

  int n_chk = 0, n_bad = 0;
  logic [63:0] m_fs = '0, m_gs = '0, m_alt = '0;

  localparam logic [31:0] I_FS = 32'hC000_0100, I_GS = 32'hC000_0101, I_ALT = 32'hC000_0102;

  always #2 clk = ~clk;

  seg_base_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .mode64_i(mode64), .cpl_i(cpl),
    .msr_wr_i(msr_wr), .msr_rd_i(msr_rd), .msr_idx_i(idx),
    .msr_wdata_lo_i(wlo), .msr_wdata_hi_i(whi), .msr_rdata_o(rdata), .msr_err_o(err),
    .sel_ld_i(sel_ld), .sel_seg_i(sel_seg), .desc_i(desc),
    .swap_i(swap), .swap_fault_o(fault),
    .ea_valid_i(ea_valid), .ea_seg_i(ea_seg), .ea_off_i(ea_off),
    .ea_valid_o(ea_vo), .ea_o(ea)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    mode64 = 1'b1; cpl = 2'd0; msr_wr = 0; msr_rd = 0; idx = '0; wlo = '0; whi = '0;
    sel_ld = 0; sel_seg = 0; desc = '0; swap = 0; ea_valid = 0; ea_seg = 0; ea_off = '0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [31:0] i, output logic [63:0] d, output logic e);
    msr_rd = 1; idx = i; #1;
    d = rdata; e = err;
    msr_rd = 0; idx = '0;
  endtask

  task automatic check_all(input string req);
    logic [63:0] d; logic e;
    rd(I_FS, d, e);  chk({req, " fs"}, d, m_fs);
    rd(I_GS, d, e);  chk({req, " gs"}, d, m_gs);
    rd(I_ALT, d, e); chk({req, " alt"}, d, m_alt);
  endtask

  task automatic wr(input logic [31:0] i, input logic [63:0] v);
    msr_wr = 1; idx = i; wlo = v[31:0]; whi = v[63:32];
    tick();
    msr_wr = 0; idx = '0;
  endtask

  function automatic logic [63:0] scatter(input logic [31:0] b, input logic [31:0] junk);
    return {b[31:24], junk[31:16], b[23:16], b[15:0], junk[15:0]};
  endfunction

  function automatic logic [63:0] vpat(input int k);
    logic [31:0] a, b;
    a = 32'(k) * 32'h9E37_79B9;
    b = ~(32'(k) * 32'h85EB_CA6B);
    return {a, b};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] d; logic e;
    idle();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 ea_valid", {63'd0, ea_vo}, 64'd0);
    chk("R10 fault", {63'd0, fault}, 64'd0);
    check_all("R10");
    rst_n = 1'b1;
    tick();

    // R1 R2 full writes to each index
    for (int k = 1; k <= 12; k++) begin
      logic [63:0] v; v = vpat(k);
      unique case (k % 3)
        0: begin wr(I_FS, v);  m_fs  = v; end
        1: begin wr(I_GS, v);  m_gs  = v; end
        default: begin wr(I_ALT, v); m_alt = v; end
      endcase
      check_all("R1 R2");
    end
    wr(I_FS, 64'hFFFF_FFFF_FFFF_FFFF); m_fs = 64'hFFFF_FFFF_FFFF_FFFF;
    check_all("R2 all ones");

    // R3 selector loads with junk in unused fields
    for (int k = 0; k < 16; k++) begin
      logic [31:0] b, j;
      b = vpat(k + 40)[31:0]; j = vpat(k + 90)[63:32];
      sel_ld = 1; sel_seg = k[0]; desc = scatter(b, j);
      tick();
      sel_ld = 0;
      if (k[0]) m_gs[31:0] = b; else m_fs[31:0] = b;
      check_all("R3");
    end

    // R9 unknown indices
    for (int k = 0; k < 6; k++) begin
      logic [31:0] bi;
      unique case (k)
        0: bi = 32'hC000_00FF; 1: bi = 32'hC000_0103; 2: bi = 32'h0000_0000;
        3: bi = 32'h0000_0100; 4: bi = 32'h4000_0101; default: bi = 32'hFFFF_FFFF;
      endcase
      rd(bi, d, e);
      chk("R9 read err", {63'd0, e}, 64'd1);
      chk("R9 read zero", d, 64'd0);
      msr_wr = 1; idx = bi; wlo = 32'hDEAD_BEEF; whi = 32'hCAFE_F00D; #1;
      chk("R9 write err", {63'd0, err}, 64'd1);
      tick();
      msr_wr = 0; idx = '0;
      check_all("R9 no change");
    end
    rd(I_GS, d, e);
    chk("R9 no err on valid idx", {63'd0, e}, 64'd0);

    // R7 permitted swap
    for (int k = 0; k < 3; k++) begin
      logic [63:0] t;
      swap = 1; mode64 = 1; cpl = 0;
      tick();
      swap = 0;
      chk("R7 no fault", {63'd0, fault}, 64'd0);
      t = m_gs; m_gs = m_alt; m_alt = t;
      check_all("R7");
    end

    // R8 refused swaps: every cpl in compat, cpl 1..3 in 64-bit
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 4; c++) begin
        if (m == 1 && c == 0) continue;
        swap = 1; mode64 = m[0]; cpl = c[1:0];
        tick();
        swap = 0; mode64 = 1; cpl = 0;
        chk("R8 fault pulse", {63'd0, fault}, 64'd1);
        check_all("R8 unchanged");
        tick();
        chk("R8 fault drops", {63'd0, fault}, 64'd0);
      end
    end

    // R11 priorities
    msr_wr = 1; idx = I_GS; wlo = 32'h1111_2222; whi = 32'h3333_4444;
    sel_ld = 1; sel_seg = 1; desc = scatter(32'hAAAA_BBBB, 32'h5A5A_A5A5);
    tick();
    msr_wr = 0; sel_ld = 0; idx = '0;
    m_gs = 64'h3333_4444_1111_2222;
    check_all("R11 msr beats load");

    msr_wr = 1; idx = I_ALT; wlo = 32'h0BAD_0001; whi = 32'h0BAD_0002; swap = 1;
    tick();
    msr_wr = 0; swap = 0; idx = '0;
    m_alt = 64'h0BAD_0002_0BAD_0001;
    chk("R11 no fault", {63'd0, fault}, 64'd0);
    check_all("R11 swap dropped on alt write");

    sel_ld = 1; sel_seg = 1; desc = scatter(32'h7654_3210, 32'hFFFF_FFFF); swap = 1;
    tick();
    sel_ld = 0; swap = 0;
    m_gs[31:0] = 32'h7654_3210;
    check_all("R11 swap dropped on gs load");

    // R4 R5 R6 effective address sweep
    wr(I_FS, 64'h8000_0001_FFFF_FFF0); m_fs = 64'h8000_0001_FFFF_FFF0;
    wr(I_GS, 64'hFFFF_FFFF_0000_1000); m_gs = 64'hFFFF_FFFF_0000_1000;
    for (int s = 0; s < 2; s++) begin
      for (int m = 0; m < 2; m++) begin
        for (int k = 0; k < 8; k++) begin
          logic [63:0] off, b, exp;
          logic [31:0] lo;
          unique case (k)
            0: off = 64'd0;
            1: off = 64'h10;
            2: off = 64'h0000_0000_FFFF_FFFF;
            3: off = 64'hFFFF_FFFF_FFFF_FFFF;
            4: off = 64'h7FFF_FFFE_0000_0010;
            default: off = vpat(k + 200);
          endcase
          b = s[0] ? m_gs : m_fs;
          lo = b[31:0] + off[31:0];
          exp = m[0] ? (b + off) : {32'd0, lo};
          ea_valid = 1; ea_seg = s[0]; mode64 = m[0]; ea_off = off;
          chk("R6 not early", {63'd0, ea_vo}, (k == 0 && s == 0 && m == 0) ? 64'd0 : 64'd1);
          tick();
          chk("R6 valid", {63'd0, ea_vo}, 64'd1);
          chk(m[0] ? "R5 ea64" : "R4 ea32", ea, exp);
        end
      end
    end
    ea_valid = 0; mode64 = 1;
    tick();
    chk("R6 valid drops", {63'd0, ea_vo}, 64'd0);

    // R6 same-edge write: base before the update is used
    ea_valid = 1; ea_seg = 0; mode64 = 1; ea_off = 64'h5;
    msr_wr = 1; idx = I_FS; wlo = 32'h0; whi = 32'h0;
    tick();
    msr_wr = 0; ea_valid = 0; idx = '0;
    chk("R6 old base", ea, m_fs + 64'h5);
    m_fs = '0;
    check_all("R6 write landed");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule